// File: doc/BRIEF.md
# In-Flight Sequence Number Allocator

This block sits at the fetch end of a pipeline and hands a sequence number to each instruction it accepts. The pool holds `NUM_SEQ` numbers, and that count is also the limit on how many instructions can be in flight at once. A number is held from the cycle its instruction is fetched until that instruction commits. When every number is held, the block drops its grant and fetch waits.

Numbers are issued in rising modular order, so their order follows program order. Commit reports each retiring number back, and that number becomes free again. On a squash, the issue pointer moves back to just past a surviving number, and every number younger than that survivor is reclaimed in the same step.

Top module: `seq_alloc`

## Requirements
- R1: After reset every number is free, `grant_seq` reads 0, and the first request is granted with number 0.
- R2: `fetch_gnt` is high in the same cycle as `fetch_req` exactly when the number at the issue pointer is free and `squash_vld` is low. `grant_seq` is the number attached in that cycle.
- R3: After a grant without a squash, `grant_seq` is the previous number plus one, and it wraps from `NUM_SEQ-1` to 0.
- R4: While all `NUM_SEQ` numbers are held and no commit frees the number at the pointer, `fetch_gnt` stays low and the pointer does not move.
- R5: A number named by `commit_vld`/`commit_seq` becomes free from the next cycle on, and a later request can be granted with it.
- R6: A commit and a grant in the same cycle both take effect. This includes a commit of the very number at the pointer while the pool is full: the grant is given in that same cycle and the number stays held by the new instruction.
- R7: With `squash_vld` high, `grant_seq` in the next cycle is `squash_seq+1` (mod `NUM_SEQ`). All numbers younger than `squash_seq` up to the old pointer become free, and `squash_seq` itself and every older number stay held.
- R8: A request in a cycle where `squash_vld` is high is not granted.
- R9: With neither a grant nor a squash, `grant_seq` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Fetch wants a number this cycle |
| fetch_gnt | output | 1 | Number granted this cycle |
| grant_seq | output | $clog2(NUM_SEQ) | Number at the issue pointer, attached when granted |
| commit_vld | input | 1 | A committing instruction returns its number |
| commit_seq | input | $clog2(NUM_SEQ) | Number being returned; must be held |
| squash_vld | input | 1 | Roll back to just past `squash_seq` |
| squash_seq | input | $clog2(NUM_SEQ) | Youngest surviving number; must be held |

## Verification
`fetch_gnt` and `grant_seq` depend on logic that passes through no register, so both are due in the cycle the inputs are driven. That includes the commit bypass that lets a full pool grant the number being returned. A commit's effect on any other number, the pointer step after a grant, and the pointer rewind after a squash all show up one edge later. The bench drives inputs on the falling edge and compares the outputs 1 ns later against a queue-based model that it advances only at the next rising edge. Each cycle's comparison therefore sees exactly the state left by all earlier edges.

// File: rtl/seq_alloc_pkg.sv
`timescale 1ns/1ps
package seq_alloc_pkg;
   // action applied to the issue pointer at the next edge
   typedef enum logic [1:0] {
      PTR_HOLD    = 2'd0,
      PTR_ADVANCE = 2'd1,
      PTR_REWIND  = 2'd2
   } ptr_op_e;
endpackage

// File: rtl/seq_alloc_ptr.sv
`timescale 1ns/1ps
module seq_alloc_ptr
   import seq_alloc_pkg::*;
#(
   parameter int NUM_SEQ = 8,
   parameter int SEQ_W   = $clog2(NUM_SEQ)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ptr_op_e          op,
   input  logic [SEQ_W-1:0] rewind_base,
   output logic [SEQ_W-1:0] ptr_q
);
   localparam bit          IS_POW2 = (NUM_SEQ & (NUM_SEQ - 1)) == 0;
   localparam [SEQ_W-1:0]  LAST    = SEQ_W'(NUM_SEQ - 1);

   logic [SEQ_W-1:0] adv_nxt;
   logic [SEQ_W-1:0] rew_nxt;

   generate
      if (IS_POW2) begin : g_pow2
         // natural wrap of the counter width
         assign adv_nxt = ptr_q + 1'b1;
         assign rew_nxt = rewind_base + 1'b1;
      end else begin : g_mod
         assign adv_nxt = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
         assign rew_nxt = (rewind_base == LAST) ? '0 : rewind_base + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else begin
         unique case (op)
            PTR_ADVANCE: ptr_q <= adv_nxt;
            PTR_REWIND:  ptr_q <= rew_nxt;
            default:     ptr_q <= ptr_q;
         endcase
      end
   end
endmodule

// File: rtl/seq_alloc_busy.sv
`timescale 1ns/1ps
module seq_alloc_busy #(
   parameter int NUM_SEQ = 8,
   parameter int SEQ_W   = $clog2(NUM_SEQ)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               alloc_en,
   input  logic [SEQ_W-1:0]   alloc_idx,
   input  logic               commit_vld,
   input  logic [SEQ_W-1:0]   commit_idx,
   input  logic               flush,
   input  logic [SEQ_W-1:0]   flush_base,
   output logic [NUM_SEQ-1:0] busy_q
);
   // count of numbers younger than flush_base, up to the pointer
   int flush_span;

   always_comb begin
      flush_span = int'(alloc_idx) - int'(flush_base) - 1;
      if (flush_span < 0) flush_span = flush_span + NUM_SEQ;
   end

   generate
      for (genvar i = 0; i < NUM_SEQ; i++) begin : g_entry
         int   age;
         logic set_i;
         logic clr_i;

         always_comb begin
            age = i - int'(flush_base) - 1;
            if (age < 0) age = age + NUM_SEQ;
            set_i = alloc_en && (alloc_idx == SEQ_W'(i));
            clr_i = (commit_vld && (commit_idx == SEQ_W'(i))) ||
                    (flush && (age < flush_span));
         end

         always_ff @(posedge clk) begin
            if (!rst_n)     busy_q[i] <= 1'b0;
            else if (set_i) busy_q[i] <= 1'b1;   // a fresh owner wins
            else if (clr_i) busy_q[i] <= 1'b0;
         end
      end
   endgenerate

   // R4: only a free number, or one returned in this cycle, is handed out
   assert_alloc_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> (!busy_q[alloc_idx] || (commit_vld && commit_idx == alloc_idx)));

   // R6: a granted number is held afterwards, even if returned that cycle
   assert_alloc_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |=> busy_q[$past(alloc_idx)]);

   // R5: a returned number is free next cycle unless reissued at once
   assert_commit_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_vld && !(alloc_en && alloc_idx == commit_idx)) |=> !busy_q[$past(commit_idx)]);

   // R7: the surviving number itself is never reclaimed by a squash
   assert_flush_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && busy_q[flush_base] && !(commit_vld && commit_idx == flush_base))
      |=> busy_q[$past(flush_base)]);
endmodule

// File: rtl/seq_alloc.sv
`timescale 1ns/1ps
module seq_alloc
   import seq_alloc_pkg::*;
#(
   parameter int NUM_SEQ = 8,
   parameter int SEQ_W   = $clog2(NUM_SEQ)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fetch_req,
   output logic             fetch_gnt,
   output logic [SEQ_W-1:0] grant_seq,
   input  logic             commit_vld,
   input  logic [SEQ_W-1:0] commit_seq,
   input  logic             squash_vld,
   input  logic [SEQ_W-1:0] squash_seq
);
   generate
      if (NUM_SEQ < 2) begin : g_bad_depth
         $error("seq_alloc: NUM_SEQ must be at least 2");
      end
      if (SEQ_W < $clog2(NUM_SEQ)) begin : g_bad_width
         $error("seq_alloc: SEQ_W too narrow for NUM_SEQ");
      end
   endgenerate

   logic [NUM_SEQ-1:0] busy;
   logic [SEQ_W-1:0]   ptr;
   logic               slot_free;
   ptr_op_e            op;

   // the number at the pointer may be returned in this very cycle
   assign slot_free = !busy[ptr] || (commit_vld && commit_seq == ptr);
   assign fetch_gnt = fetch_req && slot_free && !squash_vld;
   assign grant_seq = ptr;

   always_comb begin
      if (squash_vld)     op = PTR_REWIND;
      else if (fetch_gnt) op = PTR_ADVANCE;
      else                op = PTR_HOLD;
   end

   seq_alloc_ptr #(.NUM_SEQ(NUM_SEQ), .SEQ_W(SEQ_W)) u_ptr (
      .clk         (clk),
      .rst_n       (rst_n),
      .op          (op),
      .rewind_base (squash_seq),
      .ptr_q       (ptr)
   );

   seq_alloc_busy #(.NUM_SEQ(NUM_SEQ), .SEQ_W(SEQ_W)) u_busy (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_en   (fetch_gnt),
      .alloc_idx  (ptr),
      .commit_vld (commit_vld),
      .commit_idx (commit_seq),
      .flush      (squash_vld),
      .flush_base (squash_seq),
      .busy_q     (busy)
   );

   function automatic logic [SEQ_W-1:0] step_of(input logic [SEQ_W-1:0] v);
      return (v == SEQ_W'(NUM_SEQ - 1)) ? '0 : v + 1'b1;
   endfunction

   // R3: consecutive grants carry consecutive modular numbers
   assert_in_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_gnt && !squash_vld) |=> grant_seq == step_of($past(grant_seq)));

   // R7: after a squash the next number follows the survivor
   assert_rewind_R7: assert property (@(posedge clk) disable iff (!rst_n)
      squash_vld |=> grant_seq == step_of($past(squash_seq)));

   // R9: no grant and no squash leaves the pointer in place
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_gnt && !squash_vld) |=> $stable(grant_seq));

   // R8: a squash cycle never moves the pointer forward by a grant
   assert_no_grant_on_squash_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (squash_vld && fetch_req) |=> grant_seq == step_of($past(squash_seq)));
endmodule

// File: tb/sim_seq_alloc.sv
`timescale 1ns/1ps
module sim_seq_alloc;
   localparam int NS = 8;
   localparam int SW = $clog2(NS);

   logic          clk = 1'b0;
   logic          rst_n;
   logic          fetch_req;
   logic          fetch_gnt;
   logic [SW-1:0] grant_seq;
   logic          commit_vld;
   logic [SW-1:0] commit_seq;
   logic          squash_vld;
   logic [SW-1:0] squash_seq;

   always #2.5 clk = ~clk;   // 200 MHz

   seq_alloc #(.NUM_SEQ(NS)) u0 (
      .clk(clk), .rst_n(rst_n),
      .fetch_req(fetch_req), .fetch_gnt(fetch_gnt), .grant_seq(grant_seq),
      .commit_vld(commit_vld), .commit_seq(commit_seq),
      .squash_vld(squash_vld), .squash_seq(squash_seq)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // behavioural model: held numbers in program order plus a free map
   bit busy_m [NS];
   int ptr_m = 0;
   int held [$];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   // one cycle: drive at the falling edge, compare 1 ns later, model at rising edge
   task automatic step(input bit req, input bit cv, input bit sv, input int ss,
                       input string tag);
      bit  c_ok;
      int  cs;
      bit  exp_gnt;
      c_ok = cv && (held.size() > 0);
      cs   = c_ok ? held[0] : 0;
      @(negedge clk);
      fetch_req  = req;
      commit_vld = c_ok;
      commit_seq = SW'(cs);
      squash_vld = sv;
      squash_seq = SW'(ss);
      #1;
      exp_gnt = req && !sv && (!busy_m[ptr_m] || (c_ok && cs == ptr_m));
      chk(fetch_gnt == exp_gnt, {tag, " grant"}, int'(fetch_gnt), int'(exp_gnt));
      chk(int'(grant_seq) == ptr_m, {tag, " number"}, int'(grant_seq), ptr_m);
      @(posedge clk);
      if (c_ok) begin
         busy_m[cs] = 0;
         void'(held.pop_front());
      end
      if (sv) begin
         for (int k = (ss + 1) % NS; k != ptr_m; k = (k + 1) % NS) busy_m[k] = 0;
         ptr_m = (ss + 1) % NS;
         while (held.size() > 0 && held[$] != ss) void'(held.pop_back());
      end else if (exp_gnt) begin
         busy_m[ptr_m] = 1;
         held.push_back(ptr_m);
         ptr_m = (ptr_m + 1) % NS;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog R2 actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 0; fetch_req = 0; commit_vld = 0; commit_seq = '0;
      squash_vld = 0; squash_seq = '0;
      for (int i = 0; i < NS; i++) busy_m[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;

      // R1: reset state, then number 0 first
      step(0, 0, 0, 0, "R1");
      step(1, 0, 0, 0, "R1");
      // R3: fill the pool in order 1..7
      for (int i = 1; i < NS; i++) step(1, 0, 0, 0, "R3");
      // R4: full pool stalls fetch
      step(1, 0, 0, 0, "R4");
      step(1, 0, 0, 0, "R4");
      // R6: returning the number at the pointer grants it in the same cycle
      step(1, 1, 0, 0, "R6");
      // R5: release 1, then a later request takes it
      step(0, 1, 0, 0, "R5");
      step(1, 0, 0, 0, "R5");
      // R9: idle cycles leave the pointer put
      for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R9");
      // R6: commit and grant together, three cycles running
      for (int i = 0; i < 3; i++) step(1, 1, 0, 0, "R6");
      // R8: squash at 7 while requesting: no grant
      step(1, 0, 1, 7, "R8");
      // R7: pointer is back at 0 and 0..4 are free again
      for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "R7");
      step(1, 0, 0, 0, "R7");   // pool full again: no grant
      // R7: squash on the youngest number frees nothing
      step(0, 0, 1, held[$], "R7");
      step(1, 0, 0, 0, "R7");

      // R2: mixed traffic against the model
      for (int n = 0; n < 3000; n++) begin
         bit r, c, s;
         int sq;
         r  = ($urandom % 4) != 0;
         c  = (held.size() > 0) && (($urandom % 3) == 0);
         s  = !c && (held.size() > 0) && (($urandom % 16) == 0);
         sq = s ? held[$urandom % held.size()] : 0;
         step(r, c, s, sq, "R2");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule